// File: doc/BRIEF.md
# Boundary-Scan Instruction Decoder and Pad Test Control

This block sits between a boundary-scan TAP state machine and the pads of a chip. It reads the instruction held in the TAP's instruction register and the TAP's state strobes (capture, shift and update of the data register, shift and update of the instruction register, and the test-logic-reset state). From these it decides which data register forms the serial path from `tdi` to `tdo`. It also drives the pad-level test controls and a reset request for the core logic. The TAP state machine and the boundary-scan cell chain are outside the block. The chain is seen only through a serial output pin and two controls: a select and an update enable.

Inside, the block holds a one-bit bypass register and a one-bit test-control shift stage with a parallel hold register. There are five instruction opcodes, and each one is a parameter:

- external test: the chain is in the path, and the pads drive the update-stage values and directions.
- sample/preload: the chain is in the path, and the pads are left alone.
- high-impedance: every driver is off, and the bypass bit is in the path.
- clamp: the bypass bit is in the path, and the pads hold the update-stage values.
- test-control: the test-control stage is in the path.

External test, high-impedance and clamp also hold the core in reset. Any other opcode behaves as bypass.

The decode, the pad controls and the reset request are all captured on the falling `tck` edge. So are `tdo` and its enable. The shift stages move on the rising edge.

Top module: `jtag_test_ctrl`

## Requirements
- R1: Async reset (`rstN` low), and `tapReset` seen at a falling `tck` edge, each do the following: select bypass, clear `testCtrlHold`, drive `bsrSelect`, `padBsrDrive`, `padDirFromBsr`, `padHiz`, `sysRstReq` and `bsrUpdateEn` low.
- R2: With opcode 0x0 (external test) decoded, the outputs are `bsrSelect`=1, `padBsrDrive`=1, `padDirFromBsr`=1, `sysRstReq`=1 and `padHiz`=0. `tdo` carries `bsrScanOut` while shifting the data register.
- R3: With opcode 0x1 (sample/preload) decoded, `bsrSelect`=1 and every pad override and `sysRstReq` are 0.
- R4: With opcode 0x9 (high-impedance) decoded, the outputs are `padHiz`=1, `sysRstReq`=1, `padBsrDrive`=0 and `bsrSelect`=0, and the bypass bit forms the data path.
- R5: With opcode 0xC (clamp) decoded, the outputs are `padBsrDrive`=1, `padDirFromBsr`=1, `sysRstReq`=1, `padHiz`=0 and `bsrSelect`=0, and the bypass bit forms the data path.
- R6: With opcode 0xD decoded, the following holds:
  - The test-control stage forms the data path.
  - Capture loads it from the hold register.
  - A falling edge while `updateDr` is high copies it into `testCtrlHold`.
  - Update-DR under any other instruction leaves `testCtrlHold` unchanged.
- R7: When the bypass bit is selected, capture loads 0. The first `tdo` bit of a shift is therefore 0, and each following bit is `tdi` from one cycle earlier.
- R8: The all-ones opcode (0xF) and every opcode not listed above decode as bypass.
- R9: A new decode, and with it the pad controls and `sysRstReq`, is taken only at a falling edge while `updateIr` is high. Changing `irValue` at any other time has no effect.
- R10: `bsrUpdateEn` is 1 for one cycle, starting at the falling edge taken during Update-DR, when the chain is selected. Otherwise it is 0.
- R11: At each falling edge, `tdoEn` is set to whether a shift (DR or IR) is in progress. During an IR shift, `tdo` carries `irTdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tapReset | input | 1 | TAP is in Test-Logic-Reset |
| captureDr | input | 1 | TAP in Capture-DR |
| shiftDr | input | 1 | TAP in Shift-DR |
| updateDr | input | 1 | TAP in Update-DR |
| shiftIr | input | 1 | TAP in Shift-IR |
| updateIr | input | 1 | TAP in Update-IR |
| irValue | input | IR_W | Latched instruction register |
| tdi | input | 1 | Serial test data in |
| irTdo | input | 1 | Serial output of the instruction shift path |
| bsrScanOut | input | 1 | Serial output of the boundary-scan chain |
| tdo | output | 1 | Serial test data out (falling-edge register) |
| tdoEn | output | 1 | Output enable for `tdo` |
| bsrSelect | output | 1 | Boundary-scan chain is in the data path |
| bsrUpdateEn | output | 1 | Load the chain's update stage |
| padBsrDrive | output | 1 | Pads take output values from the chain update stage |
| padDirFromBsr | output | 1 | Bidirectional pad directions come from the chain |
| padHiz | output | 1 | Force every pad driver off |
| sysRstReq | output | 1 | Hold the core logic in reset |
| testCtrlHold | output | 1 | Parallel hold of the test-control bit |

## Verification
The hardest state to reach is a `testCtrlHold` value that was written under the test-control instruction and must then survive an Update-DR under a different instruction. The stimulus loads opcode 0xD and shifts a 1 into the stage. It commits that value with Update-DR, switches to bypass and issues Update-DR again. It also captures under 0xD, so the held value shows up as the first `tdo` bit. A reference model in the bench compares every output on every clock, with the check label set by the scenario under way. That scenario list also covers an `irValue` change without Update-IR and a TAP reset while external test is active.

// File: rtl/jtag_tc_pkg.sv
package jtag_tc_pkg;

  typedef enum logic [2:0] {
    INS_BYPASS,
    INS_EXTEST,
    INS_SAMPLE,
    INS_HIGHZ,
    INS_CLAMP,
    INS_TESTCTRL
  } instr_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;
    logic shift;
    logic updDr;
    logic selBsr;
    logic selTestCtrl;
  } dpCtl_t;

endpackage

// File: rtl/jtag_tc_ctrl.sv
module jtag_tc_ctrl
  import jtag_tc_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OP_EXTEST   = 'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 'h1,
  parameter logic [IR_W-1:0] OP_HIGHZ    = 'h9,
  parameter logic [IR_W-1:0] OP_CLAMP    = 'hC,
  parameter logic [IR_W-1:0] OP_TESTCTRL = 'hD
) (
  input  logic            tck,
  input  logic            rstN,
  input  logic            tapReset,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            updateIr,
  input  logic [IR_W-1:0] irValue,
  output dpCtl_t          dpCtl,
  output logic            bsrSelect,
  output logic            bsrUpdateEn,
  output logic            padBsrDrive,
  output logic            padDirFromBsr,
  output logic            padHiz,
  output logic            sysRstReq
);

  localparam logic [IR_W-1:0] OP_ALLONES = '1;

  instr_e instrQ;
  instr_e instrNext;

  // opcode decode; all-ones and unknown codes fall back to bypass
  always_comb begin
    if (irValue == OP_ALLONES)          instrNext = INS_BYPASS;
    else if (irValue == OP_EXTEST)      instrNext = INS_EXTEST;
    else if (irValue == OP_SAMPLE)      instrNext = INS_SAMPLE;
    else if (irValue == OP_HIGHZ)       instrNext = INS_HIGHZ;
    else if (irValue == OP_CLAMP)       instrNext = INS_CLAMP;
    else if (irValue == OP_TESTCTRL)    instrNext = INS_TESTCTRL;
    else                                instrNext = INS_BYPASS;
  end

  logic nextBsrSel, nextBsrDrive, nextDir, nextHiz, nextRst;

  always_comb begin
    nextBsrSel   = (instrNext == INS_EXTEST) || (instrNext == INS_SAMPLE);
    nextBsrDrive = (instrNext == INS_EXTEST) || (instrNext == INS_CLAMP);
    nextDir      = (instrNext == INS_EXTEST) || (instrNext == INS_CLAMP);
    nextHiz      = (instrNext == INS_HIGHZ);
    nextRst      = (instrNext == INS_EXTEST) || (instrNext == INS_HIGHZ) ||
                   (instrNext == INS_CLAMP);
  end

  // decode and pad controls move only on the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      instrQ        <= INS_BYPASS;
      bsrSelect     <= 1'b0;
      padBsrDrive   <= 1'b0;
      padDirFromBsr <= 1'b0;
      padHiz        <= 1'b0;
      sysRstReq     <= 1'b0;
    end else if (tapReset) begin
      instrQ        <= INS_BYPASS;
      bsrSelect     <= 1'b0;
      padBsrDrive   <= 1'b0;
      padDirFromBsr <= 1'b0;
      padHiz        <= 1'b0;
      sysRstReq     <= 1'b0;
    end else if (updateIr) begin
      instrQ        <= instrNext;
      bsrSelect     <= nextBsrSel;
      padBsrDrive   <= nextBsrDrive;
      padDirFromBsr <= nextDir;
      padHiz        <= nextHiz;
      sysRstReq     <= nextRst;
    end
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)         bsrUpdateEn <= 1'b0;
    else if (tapReset) bsrUpdateEn <= 1'b0;
    else               bsrUpdateEn <= updateDr && bsrSelect;
  end

  always_comb begin
    dpCtl.capture     = captureDr;
    dpCtl.shift       = shiftDr;
    dpCtl.updDr       = updateDr;
    dpCtl.selBsr      = bsrSelect;
    dpCtl.selTestCtrl = (instrQ == INS_TESTCTRL);
  end

endmodule

// File: rtl/jtag_tc_dp.sv
module jtag_tc_dp
  import jtag_tc_pkg::*;
(
  input  logic   tck,
  input  logic   rstN,
  input  logic   tapReset,
  input  dpCtl_t dpCtl,
  input  logic   shiftIr,
  input  logic   tdi,
  input  logic   irTdo,
  input  logic   bsrScanOut,
  output logic   tdo,
  output logic   tdoEn,
  output logic   testCtrlHold
);

  logic bypassQ;
  logic tcShiftQ;
  logic selBypass;
  logic serialOut;
  logic anyShift;

  assign selBypass = !dpCtl.selBsr && !dpCtl.selTestCtrl;
  assign anyShift  = dpCtl.shift || shiftIr;

  // rising-edge shift stages
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bypassQ  <= 1'b0;
      tcShiftQ <= 1'b0;
    end else begin
      if (selBypass) begin
        if (dpCtl.capture)    bypassQ <= 1'b0;
        else if (dpCtl.shift) bypassQ <= tdi;
      end
      if (dpCtl.selTestCtrl) begin
        if (dpCtl.capture)    tcShiftQ <= testCtrlHold;
        else if (dpCtl.shift) tcShiftQ <= tdi;
      end
    end
  end

  // parallel hold of the test-control bit
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)                                    testCtrlHold <= 1'b0;
    else if (tapReset)                            testCtrlHold <= 1'b0;
    else if (dpCtl.updDr && dpCtl.selTestCtrl)    testCtrlHold <= tcShiftQ;
  end

  always_comb begin
    if (shiftIr)                serialOut = irTdo;
    else if (dpCtl.selBsr)      serialOut = bsrScanOut;
    else if (dpCtl.selTestCtrl) serialOut = tcShiftQ;
    else                        serialOut = bypassQ;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= anyShift;
      if (anyShift) tdo <= serialOut;
    end
  end

endmodule

// File: rtl/jtag_test_ctrl.sv
module jtag_test_ctrl
  import jtag_tc_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OP_EXTEST   = 'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 'h1,
  parameter logic [IR_W-1:0] OP_HIGHZ    = 'h9,
  parameter logic [IR_W-1:0] OP_CLAMP    = 'hC,
  parameter logic [IR_W-1:0] OP_TESTCTRL = 'hD
) (
  input  logic            tck,
  input  logic            rstN,
  input  logic            tapReset,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            shiftIr,
  input  logic            updateIr,
  input  logic [IR_W-1:0] irValue,
  input  logic            tdi,
  input  logic            irTdo,
  input  logic            bsrScanOut,
  output logic            tdo,
  output logic            tdoEn,
  output logic            bsrSelect,
  output logic            bsrUpdateEn,
  output logic            padBsrDrive,
  output logic            padDirFromBsr,
  output logic            padHiz,
  output logic            sysRstReq,
  output logic            testCtrlHold
);

  dpCtl_t dpCtl;

  jtag_tc_ctrl #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_HIGHZ(OP_HIGHZ), .OP_CLAMP(OP_CLAMP), .OP_TESTCTRL(OP_TESTCTRL)
  ) u_ctrl (
    .tck(tck), .rstN(rstN), .tapReset(tapReset), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .updateIr(updateIr),
    .irValue(irValue), .dpCtl(dpCtl), .bsrSelect(bsrSelect),
    .bsrUpdateEn(bsrUpdateEn), .padBsrDrive(padBsrDrive),
    .padDirFromBsr(padDirFromBsr), .padHiz(padHiz), .sysRstReq(sysRstReq)
  );

  jtag_tc_dp u_dp (
    .tck(tck), .rstN(rstN), .tapReset(tapReset), .dpCtl(dpCtl),
    .shiftIr(shiftIr), .tdi(tdi), .irTdo(irTdo), .bsrScanOut(bsrScanOut),
    .tdo(tdo), .tdoEn(tdoEn), .testCtrlHold(testCtrlHold)
  );

endmodule

// File: rtl/jtag_test_ctrl_chk.sv
module jtag_test_ctrl_chk (
  input logic tck,
  input logic rstN,
  input logic tapReset,
  input logic updateIr,
  input logic updateDr,
  input logic shiftDr,
  input logic shiftIr,
  input logic bsrSelect,
  input logic bsrUpdateEn,
  input logic padBsrDrive,
  input logic padDirFromBsr,
  input logic padHiz,
  input logic sysRstReq,
  input logic testCtrlHold,
  input logic tdoEn
);

  // R9: pad controls hold unless an instruction update happened
  a_r9_pads_hold: assert property (@(negedge tck) disable iff (!rstN)
    (!updateIr && !tapReset) |=> $stable({bsrSelect, padBsrDrive, padDirFromBsr, padHiz, sysRstReq}));

  // R1: TAP reset releases everything
  a_r1_tap_release: assert property (@(negedge tck) disable iff (!rstN)
    tapReset |=> (!sysRstReq && !padHiz && !padBsrDrive && !padDirFromBsr && !bsrSelect && !testCtrlHold));

  // R4: high impedance never combined with driving from the chain
  a_r4_hiz_excl: assert property (@(negedge tck) disable iff (!rstN)
    padHiz |-> (!padBsrDrive && sysRstReq));

  // R10: update enable follows Update-DR with the chain selected
  a_r10_upd_en: assert property (@(negedge tck) disable iff (!rstN)
    (updateDr && bsrSelect && !tapReset) |=> bsrUpdateEn);
  a_r10_upd_idle: assert property (@(negedge tck) disable iff (!rstN)
    !updateDr |=> !bsrUpdateEn);

  // R11: output enable tracks the shift states
  a_r11_tdo_en: assert property (@(negedge tck) disable iff (!rstN)
    (shiftDr || shiftIr) |=> tdoEn);
  a_r11_tdo_off: assert property (@(negedge tck) disable iff (!rstN)
    !(shiftDr || shiftIr) |=> !tdoEn);

  // R6: hold register moves only during Update-DR
  a_r6_hold_stable: assert property (@(negedge tck) disable iff (!rstN)
    (!updateDr && !tapReset) |=> $stable(testCtrlHold));

endmodule

bind jtag_test_ctrl jtag_test_ctrl_chk u_chk (
  .tck(tck), .rstN(rstN), .tapReset(tapReset), .updateIr(updateIr),
  .updateDr(updateDr), .shiftDr(shiftDr), .shiftIr(shiftIr),
  .bsrSelect(bsrSelect), .bsrUpdateEn(bsrUpdateEn), .padBsrDrive(padBsrDrive),
  .padDirFromBsr(padDirFromBsr), .padHiz(padHiz), .sysRstReq(sysRstReq),
  .testCtrlHold(testCtrlHold), .tdoEn(tdoEn)
);

// File: tb/tb_jtag_test_ctrl.sv
`timescale 1ns/1ps
module tb_jtag_test_ctrl;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic rstN = 1'b0;
  logic tapReset = 0, captureDr = 0, shiftDr = 0, updateDr = 0, shiftIr = 0, updateIr = 0;
  logic [3:0] irValue = 4'hF;
  logic tdi = 0, irTdo = 0, bsrScanOut = 0;
  logic tdo, tdoEn, bsrSelect, bsrUpdateEn, padBsrDrive, padDirFromBsr, padHiz, sysRstReq, testCtrlHold;

  jtag_test_ctrl dut (
    .tck(tck), .rstN(rstN), .tapReset(tapReset), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .shiftIr(shiftIr), .updateIr(updateIr),
    .irValue(irValue), .tdi(tdi), .irTdo(irTdo), .bsrScanOut(bsrScanOut),
    .tdo(tdo), .tdoEn(tdoEn), .bsrSelect(bsrSelect), .bsrUpdateEn(bsrUpdateEn),
    .padBsrDrive(padBsrDrive), .padDirFromBsr(padDirFromBsr), .padHiz(padHiz),
    .sysRstReq(sysRstReq), .testCtrlHold(testCtrlHold)
  );

  int checks = 0;
  int errors = 0;
  string phaseReq = "R1";

  // reference model state: 0 bypass,1 extest,2 sample,3 highz,4 clamp,5 testctrl
  int mIns = 0;
  int mHold = 0, mBypass = 0, mTc = 0, mTdo = 0, mTdoEn = 0, mUpdEn = 0;
  int sentBits[$];

  function automatic int decodeOp(input logic [3:0] op);
    case (op)
      4'h0: return 1;
      4'h1: return 2;
      4'h9: return 3;
      4'hC: return 4;
      4'hD: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", phaseReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("bsrSelect",     bsrSelect,     (mIns == 1 || mIns == 2));
    check("padBsrDrive",   padBsrDrive,   (mIns == 1 || mIns == 4));
    check("padDirFromBsr", padDirFromBsr, (mIns == 1 || mIns == 4));
    check("padHiz",        padHiz,        (mIns == 3));
    check("sysRstReq",     sysRstReq,     (mIns == 1 || mIns == 3 || mIns == 4));
    check("bsrUpdateEn",   bsrUpdateEn,   mUpdEn);
    check("testCtrlHold",  testCtrlHold,  mHold);
    check("tdoEn",         tdoEn,         mTdoEn);
    if (mTdoEn != 0) check("tdo", tdo, mTdo);
  endtask

  // one TCK cycle: drive after rising edge, model and compare after falling edge
  task automatic step(input logic cap, input logic sDr, input logic uDr,
                      input logic uIr, input logic sIr, input logic tRst,
                      input logic tdiV);
    int bsrSel, tcSel, bypSel;
    @(posedge tck); #1;
    captureDr = cap; shiftDr = sDr; updateDr = uDr; updateIr = uIr;
    shiftIr = sIr; tapReset = tRst; tdi = tdiV;
    @(negedge tck); #1;
    bsrSel = (mIns == 1 || mIns == 2);
    tcSel  = (mIns == 5);
    bypSel = !bsrSel && !tcSel;
    if (sDr || sIr)
      mTdo = sIr ? int'(irTdo) : bsrSel ? int'(bsrScanOut) : tcSel ? mTc : mBypass;
    mTdoEn = (sDr || sIr);
    mUpdEn = (!tRst && uDr && bsrSel);
    if (tRst) mHold = 0;
    else if (uDr && tcSel) mHold = mTc;
    if (tRst) mIns = 0;
    else if (uIr) mIns = decodeOp(irValue);
    compareAll();
    // rising-edge model, using the decode that is in force at that edge
    bsrSel = (mIns == 1 || mIns == 2);
    tcSel  = (mIns == 5);
    bypSel = !bsrSel && !tcSel;
    if (bypSel) begin
      if (cap) mBypass = 0;
      else if (sDr) mBypass = tdiV;
    end
    if (tcSel) begin
      if (cap) mTc = mHold;
      else if (sDr) mTc = tdiV;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic loadIr(input logic [3:0] op);
    irValue = op;
    step(0, 0, 0, 1, 0, 0, 0);
    idle();
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #1;
    // R1: reset state
    phaseReq = "R1";
    check("bsrSelect after rstN", bsrSelect, 0);
    check("sysRstReq after rstN", sysRstReq, 0);
    check("testCtrlHold after rstN", testCtrlHold, 0);
    rstN = 1'b1;
    idle(); idle();

    // R2: external test and chain shifting
    phaseReq = "R2";
    loadIr(4'h0);
    step(1, 0, 0, 0, 0, 0, 0);
    bsrScanOut = 1; step(0, 1, 0, 0, 0, 0, 0);
    bsrScanOut = 0; step(0, 1, 0, 0, 0, 0, 1);
    bsrScanOut = 1; step(0, 1, 0, 0, 0, 0, 0);
    phaseReq = "R10";
    step(0, 0, 1, 0, 0, 0, 0);
    idle();

    // R3: sample/preload
    phaseReq = "R3";
    loadIr(4'h1);
    step(0, 0, 1, 0, 0, 0, 0);
    idle();

    // R4: high impedance with bypass path
    phaseReq = "R4";
    loadIr(4'h9);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);

    // R5: clamp
    phaseReq = "R5";
    loadIr(4'hC);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0);

    // R6: test-control stage and hold
    phaseReq = "R6";
    loadIr(4'hD);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    idle();
    check("hold after update", testCtrlHold, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("first bit is held value", tdo, 1);
    step(0, 1, 0, 0, 0, 0, 0);
    loadIr(4'hF);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    idle();
    check("hold kept under bypass", testCtrlHold, 1);

    // R7: bypass captures zero then delays tdi by one
    phaseReq = "R7";
    loadIr(4'hF);
    step(1, 0, 0, 0, 0, 0, 0);
    sentBits = '{};
    for (int i = 0; i < 6; i++) begin
      logic b;
      b = logic'((i * 5 + 1) % 3 == 0);
      step(0, 1, 0, 0, 0, 0, b);
      if (i == 0) check("first bypass bit", tdo, 0);
      else check("delayed tdi", tdo, sentBits.pop_front());
      sentBits.push_back(int'(b));
    end

    // R8: unknown and all-ones opcodes
    phaseReq = "R8";
    loadIr(4'h0);
    loadIr(4'h7);
    check("unknown op no reset", sysRstReq, 0);
    check("unknown op no chain", bsrSelect, 0);
    loadIr(4'h0);
    loadIr(4'hF);
    check("all-ones no reset", sysRstReq, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    check("all-ones bypass first bit", tdo, 0);

    // R9: irValue changes ignored without Update-IR
    phaseReq = "R9";
    loadIr(4'h0);
    irValue = 4'h9;
    idle(); idle();
    check("padHiz unchanged", padHiz, 0);
    check("padBsrDrive unchanged", padBsrDrive, 1);
    irValue = 4'h1;
    step(0, 1, 0, 0, 0, 0, 1);
    idle();

    // R11: IR shift routes irTdo
    phaseReq = "R11";
    irTdo = 1; step(0, 0, 0, 0, 1, 0, 0);
    check("ir shift tdo", tdo, 1);
    irTdo = 0; step(0, 0, 0, 0, 1, 0, 1);
    irTdo = 1; step(0, 0, 0, 0, 1, 0, 0);
    idle();
    check("tdoEn low when idle", tdoEn, 0);

    // R1: TAP reset during external test with hold set
    phaseReq = "R1";
    loadIr(4'hD);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    loadIr(4'h0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("sysRstReq after tap reset", sysRstReq, 0);
    check("hold after tap reset", testCtrlHold, 0);
    idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule